// File: doc/BRIEF.md
# Downward Bit Search Unit

This unit finds the most significant set bit of a search word that lies strictly below a programmable position. The low five bits of a control word name that position. The scan starts one position beneath it and moves toward bit 0. A control field of zero is a special case: the scan then covers the whole word, starting from bit 31. The unit returns the index of the first set bit it meets and a found flag. If no examined bit is set, it returns index 0 with the flag clear. A hit on bit 0 and a miss therefore give the same index, and only the flag tells them apart.

Operands arrive on a valid/ready stream, and results leave on another. Only the low five bits of the control word are used; the rest of the word is ignored. The search itself is combinational: a window mask followed by a tree priority encoder. One output register stage holds the result, so the latency is one cycle.

The input side accepts a word whenever `in_ready` is high. `in_ready` is high when the output register is empty, or when the result it holds is taken in the same cycle. A result waiting with `out_ready` low stays unchanged, and no new operand is accepted until it leaves.

Top module: `bitscan_down`

## Requirements
- R1: When the control field `ctrl_word[4:0]` is F with F nonzero, only bits F-1 down to 0 of the search word are examined. Bits at position F and above have no effect on the outcome.
- R2: When the control field is 0, all 32 bits are examined, starting at bit 31.
- R3: On a hit, `found` is 1 and `result` is the index of the highest set bit among the examined bits.
- R4: When no examined bit is set, `result` is 0 and `found` is 0. A hit on bit 0 gives `result` 0 with `found` 1.
- R5: Bits [31:5] of `ctrl_word` have no effect on `result` or `found`.
- R6: While `out_valid` is high, bits [31:5] of `result` are zero.
- R7: An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high in the following cycle.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `result` and `found` hold their values.
- R9: After reset, `out_valid`, `result` and `found` are 0.
- R10: After a cycle in which a result is taken and no operand is accepted, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit can take an operand pair this cycle |
| search_word | input | 32 | Word to scan for set bits |
| ctrl_word | input | 32 | Low 5 bits give the scan limit; upper bits ignored |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| result | output | 32 | Index of the bit found, zero-extended; 0 on a miss |
| found | output | 1 | 1 when a set bit was found |

## Verification
The checker keeps a copy of the last accepted operands. Its hit assertions assume that `search_word` and `ctrl_word` are stable whenever `in_valid` and `in_ready` are both high. The stall assertion also assumes that `out_ready` alone governs when a result is released. The bench changes every input only at the falling clock edge. It holds an offered operand until the cycle it is accepted, and it toggles `out_ready` freely, including while `in_valid` is held against a stalled output. Words are drawn as zero, one-hot, dense and random patterns. Control words carry random upper bits, so that the cases of the ignored upper field and the zero start value are both reached often.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int unsigned BSD_DEF_WIDTH = 32;

  function automatic int unsigned bsd_idx_bits(input int unsigned width);
    int unsigned n;
    n = 0;
    while ((32'd1 << n) < width) n++;
    return (n == 0) ? 1 : n;
  endfunction
endpackage

// File: rtl/bsd_window.sv
module bsd_window #(
  parameter int unsigned DATA_W = bsd_pkg::BSD_DEF_WIDTH,
  localparam int unsigned IDX_W = bsd_pkg::bsd_idx_bits(DATA_W)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [IDX_W-1:0]  limit_i,
  output logic [DATA_W-1:0] masked_o
);
  logic [DATA_W-1:0] keep;

  // A zero limit keeps every bit; otherwise keep the bits strictly below the limit.
  assign keep     = (limit_i == '0) ? '1
                  : ((DATA_W'(1) << limit_i) - DATA_W'(1));
  assign masked_o = word_i & keep;
endmodule

// File: rtl/bsd_msb_enc.sv
module bsd_msb_enc #(
  parameter int unsigned DATA_W = bsd_pkg::BSD_DEF_WIDTH,
  localparam int unsigned IDX_W = bsd_pkg::bsd_idx_bits(DATA_W)
) (
  input  logic [DATA_W-1:0] word_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);
  // Binary tree; DATA_W must be a power of two.
  for (genvar l = 0; l <= IDX_W; l++) begin : g_lvl
    localparam int unsigned N = DATA_W >> l;
    logic [N-1:0]     v;
    logic [IDX_W-1:0] ix [N];
    if (l == 0) begin : g_leaf
      assign v = word_i;
      for (genvar j = 0; j < N; j++) begin : g_z
        assign ix[j] = '0;
      end
    end else begin : g_node
      for (genvar j = 0; j < N; j++) begin : g_pair
        logic hi_v;
        assign hi_v  = g_lvl[l-1].v[2*j+1];
        assign v[j]  = hi_v | g_lvl[l-1].v[2*j];
        assign ix[j] = hi_v ? (g_lvl[l-1].ix[2*j+1] | (IDX_W'(1) << (l-1)))
                            : g_lvl[l-1].ix[2*j];
      end
    end
  end

  assign any_o = g_lvl[IDX_W].v[0];
  assign idx_o = g_lvl[IDX_W].ix[0];
endmodule

// File: rtl/bsd_out_reg.sv
module bsd_out_reg #(
  parameter int unsigned DATA_W = bsd_pkg::BSD_DEF_WIDTH,
  localparam int unsigned IDX_W = bsd_pkg::bsd_idx_bits(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              found_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      found_o     <= 1'b0;
    end else if (take_i) begin
      out_valid_o <= 1'b1;
      result_o    <= hit_i ? DATA_W'(idx_i) : '0;
      found_o     <= hit_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bitscan_down.sv
module bitscan_down #(
  parameter int unsigned DATA_W = bsd_pkg::BSD_DEF_WIDTH,
  localparam int unsigned IDX_W = bsd_pkg::bsd_idx_bits(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] search_word,
  input  logic [DATA_W-1:0] ctrl_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result,
  output logic              found
);
  logic [DATA_W-1:0] windowed;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic              take;

  wire unused_ctrl_hi = ^ctrl_word[DATA_W-1:IDX_W];

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  bsd_window #(.DATA_W(DATA_W)) u_window (
    .word_i   (search_word),
    .limit_i  (ctrl_word[IDX_W-1:0]),
    .masked_o (windowed)
  );

  bsd_msb_enc #(.DATA_W(DATA_W)) u_enc (
    .word_i (windowed),
    .any_o  (hit),
    .idx_o  (hit_idx)
  );

  bsd_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take),
    .hit_i       (hit),
    .idx_i       (hit_idx),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .result_o    (result),
    .found_o     (found)
  );
endmodule

// File: rtl/bitscan_down_chk.sv
module bitscan_down_chk #(
  parameter int unsigned DATA_W = bsd_pkg::BSD_DEF_WIDTH,
  localparam int unsigned IDX_W = bsd_pkg::bsd_idx_bits(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] search_word,
  input logic [IDX_W-1:0]  ctrl_field,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] result,
  input logic              found
);
  logic [DATA_W-1:0] word_q;
  logic [IDX_W-1:0]  field_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      field_q <= '0;
    end else if (in_valid && in_ready) begin
      word_q  <= search_word;
      field_q <= ctrl_field;
    end
  end

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result[DATA_W-1:IDX_W] == '0));

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !found) |-> (result == '0));

  assert_hit_is_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && found) |-> word_q[result[IDX_W-1:0]]);

  assert_below_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && found && field_q != '0) |-> (result[IDX_W-1:0] < field_q));

  assert_accept_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(found)));

  assert_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind bitscan_down bitscan_down_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .search_word (search_word),
  .ctrl_field  (ctrl_word[IDX_W-1:0]),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .result      (result),
  .found       (found)
);

// File: tb/bitscan_down_test.sv
module bitscan_down_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] search_word = '0;
  logic [31:0] ctrl_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] result;
  logic        found;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  // Reference model state
  logic        m_valid = 1'b0;
  logic [31:0] m_res = '0;
  logic        m_found = 1'b0;

  always #4 clk = ~clk;

  bitscan_down uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .search_word(search_word), .ctrl_word(ctrl_word), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .found(found)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp_v);
    end
  endtask

  function automatic void ref_search(input logic [31:0] w, input logic [31:0] c,
                                     output logic [31:0] r, output logic f);
    int s;
    s = int'(c[4:0]);
    s = (s == 0) ? 31 : s - 1;
    r = '0;
    f = 1'b0;
    for (int i = s; i >= 0; i--) begin
      if (w[i]) begin
        r = 32'(i);
        f = 1'b1;
        break;
      end
    end
  endfunction

  // Behavioural model: one result slot.
  always @(posedge clk or negedge rst_n) begin
    logic [31:0] r;
    logic        f;
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_res   <= '0;
      m_found <= 1'b0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      ref_search(search_word, ctrl_word, r, f);
      m_valid <= 1'b1;
      m_res   <= r;
      m_found <= f;
    end else if (out_ready) begin
      m_valid <= 1'b0;
    end
  end

  // Compare every clock, one time unit after the edge.
  always @(posedge clk) begin
    #1;
    if (cmp_en && !done) begin
      chk("R7", "out_valid", 32'(out_valid), 32'(m_valid));
      chk("R8", "in_ready", 32'(in_ready), 32'(!m_valid || out_ready));
      if (m_valid) begin
        chk("R3", "result", result, m_res);
        chk("R3", "found", 32'(found), 32'(m_found));
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL R7 watchdog: actual=%0d expected=%0d cycles", cyc, 100000);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // Offer one operand with the output always drained, check one cycle later.
  task automatic one(input string tag, input logic [31:0] w, input logic [31:0] c,
                     input logic [31:0] exp_r, input logic exp_f);
    @(negedge clk);
    in_valid    = 1'b1;
    search_word = w;
    ctrl_word   = c;
    out_ready   = 1'b1;
    @(posedge clk);
    #1;
    chk(tag, "valid", 32'(out_valid), 32'd1);
    chk(tag, "result", result, exp_r);
    chk(tag, "found", 32'(found), 32'(exp_f));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R9", "result in reset", result, 32'd0);
    chk("R9", "found in reset", 32'(found), 32'd0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    chk("R9", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R8", "in_ready idle", 32'(in_ready), 32'd1);

    one("R2", 32'h8000_0000, 32'd0, 32'd31, 1'b1);
    one("R1", 32'h8000_0000, 32'd31, 32'd0, 1'b0);
    one("R1", 32'h0000_0010, 32'd4, 32'd0, 1'b0);
    one("R1", 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b1);
    one("R4", 32'h0000_0001, 32'd5, 32'd0, 1'b1);
    one("R4", 32'h0000_0000, 32'd0, 32'd0, 1'b0);
    one("R5", 32'h0000_0010, 32'hFFFF_FFE5, 32'd4, 1'b1);
    one("R5", 32'h0000_0010, 32'h0000_0005, 32'd4, 1'b1);
    one("R3", 32'h00F0_0F00, 32'h0000_0000, 32'd23, 1'b1);
    one("R3", 32'h00F0_0F00, 32'd20, 32'd11, 1'b1);
    one("R6", 32'hFFFF_FFFF, 32'hABCD_EF00, 32'd31, 1'b1);

    // R8: stall holds A, then B enters as soon as A leaves (R7), then drain (R10)
    @(negedge clk);
    in_valid = 1'b1; search_word = 32'h0000_0100; ctrl_word = 32'd0; out_ready = 1'b0;
    @(posedge clk); #1;
    chk("R7", "stall A result", result, 32'd8);
    @(negedge clk);
    search_word = 32'h0004_0000;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R8", "held result", result, 32'd8);
      chk("R8", "in_ready stalled", 32'(in_ready), 32'd0);
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk); #1;
    chk("R7", "B after release", result, 32'd18);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R10", "drained", 32'(out_valid), 32'd0);

    // Random traffic with back-pressure
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 3) != 0);
      if (!in_valid || in_ready) begin
        in_valid = ($urandom_range(0, 2) != 0);
        case ($urandom_range(0, 3))
          0: search_word = 32'd0;
          1: search_word = 32'd1 << $urandom_range(0, 31);
          2: search_word = $urandom() | $urandom();
          default: search_word = $urandom() & $urandom() & $urandom();
        endcase
        ctrl_word = $urandom();
        if ($urandom_range(0, 4) == 0) ctrl_word[4:0] = 5'd0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule